// File: doc/BRIEF.md
# Debounced Temperature Trip Comparator

This block watches a 14-bit temperature sample and compares it against a programmable threshold. The raw comparison result does not reach the output at once. A debounce stage holds the reported state until the opposite condition has persisted for a programmable number of slow ticks. The tick period comes from a reference tick of one microsecond, multiplied by a selectable power of sixteen. A transition of the debounced state can latch an interrupt status bit. Software clears that bit by writing a one to it.

A single write port with a two-bit select loads the control word, the threshold and the filter word, and clears the status. Software picks the comparison polarity, the edge directions that raise an interrupt, an interrupt enable and a global enable. The sensor itself and the bus decode sit outside. The parameter `REF_DIV` gives the number of core clocks in one reference microsecond.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset the state and interrupt outputs are 0, the control word is 0, the threshold is 0x3FFF and the filter word is 0.
- R2: Write select 1 loads the threshold from bits 13:0. With bit 30 of the control word clear, the raw condition is true only when temperature is strictly greater than threshold.
- R3: With control bit 30 set, the raw condition is true only when temperature is strictly less than threshold. Equal values give a false condition in both polarities.
- R4: Write select 2 loads the filter word, with div in bits 9:8 and cycles in bits 7:0. When cycles is nonzero, the state takes the value of the raw condition on the (REF_DIV*16*16^div*cycles)-th clock edge of an uninterrupted mismatch, and not before.
- R5: A mismatch that goes away, or any write of the threshold or the filter word, restarts the count, including the tick phase.
- R6: With cycles = 0 the state takes the raw condition on the next clock edge.
- R7: Control bit 31 is the global enable. While it is clear, the state is forced to 0 on the next edge and no interrupt status is latched.
- R8: Control bits 1:0 select the edges that latch status. 0 selects none, 1 selects 0-to-1 transitions of the state, 2 selects 1-to-0 transitions and 3 selects both.
- R9: The interrupt output is the status bit gated by control bit 2. Status latches whether or not that bit is set.
- R10: Writing select 3 with bit 0 set clears the status. A new edge in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_i | input | 14 | Temperature sample |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 threshold, 2 filter, 3 status clear |
| wr_data_i | input | 32 | Write data |
| state_o | output | 1 | Debounced comparison state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench samples the debounced state on the exact edge before and the edge of the expected change, for two divider settings. A counter that is off by one tick, or a prescaler that is missing, would show up there. A mismatch is broken off in mid-count and a threshold is rewritten to the same value, each during a count. A filter that kept its partial count would then flip early. Equal temperature and threshold are tried in both polarities, which catches a non-strict compare. The bench also covers each edge-direction code, a clear that lands in the same cycle as a new edge, and disabling while the state is high. A wrong design would raise spurious or lost interrupts in these cases, or leave the state stuck.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_THR  = 2'd1,
        SEL_FILT = 2'd2,
        SEL_STAT = 2'd3
    } wsel_e;

    localparam int CTRL_EN_BIT  = 31;
    localparam int CTRL_INV_BIT = 30;
    localparam int CTRL_IE_BIT  = 2;
    localparam int DIV_W        = 2;
    localparam int CYC_W        = 8;

    typedef struct packed {
        logic       en;
        logic       inv;
        logic       ie;
        logic [1:0] dir;
    } ctrl_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [CYC_W-1:0] cycles;
    } filt_t;

endpackage

// File: rtl/thermtrip_regs.sv
module thermtrip_regs
    import thermtrip_pkg::*;
#(
    parameter int TEMP_W = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [31:0]       wr_data_i,
    output ctrl_t             ctrl_o,
    output logic [TEMP_W-1:0] thr_o,
    output filt_t             filt_o,
    output logic              restart_o,
    output logic              clr_stat_o
);

    localparam logic [TEMP_W-1:0] THR_RST = '1;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [TEMP_W-1:0] thr;
        filt_t             filt;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_bits;

    assign unused_bits = ^wr_data_i[29:14];

    always_comb begin
        r_d        = r_q;
        restart_o  = 1'b0;
        clr_stat_o = 1'b0;
        if (wr_en_i) begin
            case (wsel_e'(wr_sel_i))
                SEL_CTRL: begin
                    r_d.ctrl.en  = wr_data_i[CTRL_EN_BIT];
                    r_d.ctrl.inv = wr_data_i[CTRL_INV_BIT];
                    r_d.ctrl.ie  = wr_data_i[CTRL_IE_BIT];
                    r_d.ctrl.dir = wr_data_i[1:0];
                end
                SEL_THR: begin
                    r_d.thr   = wr_data_i[TEMP_W-1:0];
                    restart_o = 1'b1;
                end
                SEL_FILT: begin
                    r_d.filt.div    = wr_data_i[CYC_W+DIV_W-1:CYC_W];
                    r_d.filt.cycles = wr_data_i[CYC_W-1:0];
                    restart_o       = 1'b1;
                end
                default: clr_stat_o = wr_data_i[0];
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.ctrl <= '0;
            r_q.thr  <= THR_RST;
            r_q.filt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_o = r_q.ctrl;
    assign thr_o  = r_q.thr;
    assign filt_o = r_q.filt;

    assert_thr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == 2'd1) |=> (thr_o == $past(wr_data_i[TEMP_W-1:0])));

endmodule

// File: rtl/thermtrip_tick.sv
module thermtrip_tick
    import thermtrip_pkg::*;
#(
    parameter int REF_DIV = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int PRE_W  = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam int SLOW_W = 4 * ((1 << DIV_W) + 0);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(REF_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [SLOW_W-1:0] slow;
    } tick_t;

    tick_t t_d, t_q;
    logic              us_tick;
    logic [SLOW_W:0]   lim;
    logic [SLOW_W-1:0] lim_m1;

    always_comb begin
        lim     = (SLOW_W+1)'(16) << {div_i, 2'b00};
        lim_m1  = SLOW_W'(lim - 1'b1);
        us_tick = (t_q.pre == PRE_LAST);
        tick_o  = us_tick && (t_q.slow == lim_m1) && !restart_i;
        t_d     = t_q;
        if (restart_i) begin
            t_d = '0;
        end else begin
            t_d.pre = us_tick ? '0 : t_q.pre + 1'b1;
            if (us_tick) begin
                t_d.slow = (t_q.slow == lim_m1) ? '0 : t_q.slow + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assert_tick_phase_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(restart_i) |-> !tick_o);

endmodule

// File: rtl/thermtrip_filter.sv
module thermtrip_filter
    import thermtrip_pkg::*;
#(
    parameter int TEMP_W = 14
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              inv_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [TEMP_W-1:0] thr_i,
    input  logic [CYC_W-1:0]  cycles_i,
    input  logic              tick_i,
    input  logic              restart_i,
    output logic              hold_clr_o,
    output logic              state_o,
    output logic              rise_o,
    output logic              fall_o
);

    typedef struct packed {
        logic             state;
        logic [CYC_W-1:0] cnt;
    } filt_state_t;

    filt_state_t f_d, f_q;
    logic        raw;
    logic        match;

    always_comb begin
        raw        = en_i && (inv_i ? (temp_i < thr_i) : (temp_i > thr_i));
        match      = (raw == f_q.state);
        hold_clr_o = !en_i || match || restart_i;
        f_d        = f_q;
        rise_o     = 1'b0;
        fall_o     = 1'b0;
        if (!en_i) begin
            f_d = '0;
        end else if (match) begin
            f_d.cnt = '0;
        end else if (cycles_i == '0) begin
            f_d.state = raw;
            f_d.cnt   = '0;
            rise_o    = raw;
            fall_o    = !raw;
        end else if (restart_i) begin
            f_d.cnt = '0;
        end else if (tick_i) begin
            if (f_q.cnt == cycles_i - 1'b1) begin
                f_d.state = raw;
                f_d.cnt   = '0;
                rise_o    = raw;
                fall_o    = !raw;
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign state_o = f_q.state;

    assert_change_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(f_q.state) |-> $past(tick_i || (cycles_i == '0) || !en_i));

    assert_bypass_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && cycles_i == '0) |=> (f_q.state == $past(raw)));

    assert_disable_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !f_q.state);

endmodule

// File: rtl/thermtrip_irq.sv
module thermtrip_irq (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] dir_i,
    input  logic       ie_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       clr_i,
    output logic       irq_o
);

    typedef struct packed {
        logic status;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic       set_evt;

    always_comb begin
        set_evt    = en_i && ((rise_i && dir_i[0]) || (fall_i && dir_i[1]));
        s_d.status = set_evt || (s_q.status && !clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign irq_o = s_q.status && ie_i;

    assert_no_latch_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.status) |-> $past(en_i && (rise_i || fall_i)));

    assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clr_i && !rise_i && !fall_i) |-> !s_q.status);

endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
    import thermtrip_pkg::*;
#(
    parameter int TEMP_W  = 14,
    parameter int REF_DIV = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [31:0]       wr_data_i,
    output logic              state_o,
    output logic              irq_o
);

    ctrl_t             ctrl;
    filt_t             filt;
    logic [TEMP_W-1:0] thr;
    logic              restart;
    logic              clr_stat;
    logic              hold_clr;
    logic              tick;
    logic              rise;
    logic              fall;

    thermtrip_regs #(.TEMP_W(TEMP_W)) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .ctrl_o     (ctrl),
        .thr_o      (thr),
        .filt_o     (filt),
        .restart_o  (restart),
        .clr_stat_o (clr_stat)
    );

    thermtrip_tick #(.REF_DIV(REF_DIV)) tick_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (hold_clr),
        .div_i     (filt.div),
        .tick_o    (tick)
    );

    thermtrip_filter #(.TEMP_W(TEMP_W)) filt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (ctrl.en),
        .inv_i      (ctrl.inv),
        .temp_i     (temp_i),
        .thr_i      (thr),
        .cycles_i   (filt.cycles),
        .tick_i     (tick),
        .restart_i  (restart),
        .hold_clr_o (hold_clr),
        .state_o    (state_o),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    thermtrip_irq irq_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (ctrl.en),
        .dir_i  (ctrl.dir),
        .ie_i   (ctrl.ie),
        .rise_i (rise),
        .fall_i (fall),
        .clr_i  (clr_stat),
        .irq_o  (irq_o)
    );

    assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ctrl.ie);

endmodule

// File: tb/thermal_trip_monitor_tb_top.sv
module thermal_trip_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REFD       = 2;
    localparam int NV         = 8;
    localparam int N0         = REFD * 16 * 3;
    localparam int N1         = REFD * 256;

    // {inv, temp, thr, expected state}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 14'h0101, 14'h0100, 1'b1},
        {1'b0, 14'h0100, 14'h0100, 1'b0},
        {1'b0, 14'h0000, 14'h0000, 1'b0},
        {1'b0, 14'h3FFF, 14'h3FFE, 1'b1},
        {1'b1, 14'h00FF, 14'h0100, 1'b1},
        {1'b1, 14'h0100, 14'h0100, 1'b0},
        {1'b1, 14'h3FFF, 14'h0000, 1'b0},
        {1'b1, 14'h0000, 14'h3FFF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] temp = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        state;
    logic        irq;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_trip_monitor #(.TEMP_W(14), .REF_DIV(REFD)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .temp_i    (temp),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .state_o   (state),
        .irq_o     (irq)
    );

    function automatic logic [31:0] ctrl_w(logic en, logic inv, logic ie, logic [1:0] dir);
        return {en, inv, 27'd0, ie, dir};
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_temp(logic [13:0] v);
        @(negedge clk);
        temp = v;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 state after reset", state, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: threshold resets to 0x3FFF, filter resets to bypass
        wr(2'd0, ctrl_w(1, 0, 0, 0));
        set_temp(14'h3FFF);
        edges(2);
        chk("R1 reset threshold, normal", state, 1'b0);
        wr(2'd0, ctrl_w(1, 1, 0, 0));
        set_temp(14'h3FFE);
        edges(1);
        chk("R1 reset threshold/filter, inverted", state, 1'b1);

        // R2 / R3: compare table
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, ctrl_w(1, VEC[i][29], 0, 0));
            wr(2'd1, {18'd0, VEC[i][14:1]});
            set_temp(VEC[i][28:15]);
            edges(2);
            chk(VEC[i][29] ? "R3 inverted compare" : "R2 normal compare", state, VEC[i][0]);
        end

        // R4: filter timing, div 0 cycles 3
        wr(2'd0, ctrl_w(1, 0, 1, 3));
        wr(2'd1, 32'd100);
        set_temp(14'd50);
        edges(2);
        wr(2'd3, 32'd1);
        wr(2'd2, {22'd0, 2'd0, 8'd3});
        set_temp(14'd200);
        edges(N0 - 1);
        chk("R4 rise held before last tick", state, 1'b0);
        edges(1);
        chk("R4 rise on last tick", state, 1'b1);
        chk("R8 both-edge irq on rise", irq, 1'b1);
        wr(2'd3, 32'd1);
        edges(0);
        chk("R10 status cleared", irq, 1'b0);
        set_temp(14'd50);
        edges(N0 - 1);
        chk("R4 fall held before last tick", state, 1'b1);
        edges(1);
        chk("R4 fall on last tick", state, 1'b0);
        chk("R8 both-edge irq on fall", irq, 1'b1);
        wr(2'd3, 32'd1);

        // R5: mismatch interrupted mid-count
        set_temp(14'd200);
        edges(50);
        set_temp(14'd50);
        set_temp(14'd200);
        edges(N0 - 1);
        chk("R5 restart after mismatch drop, early", state, 1'b0);
        edges(1);
        chk("R5 restart after mismatch drop, due", state, 1'b1);
        wr(2'd3, 32'd1);

        // R5: threshold rewrite restarts the count
        set_temp(14'd50);
        edges(40);
        wr(2'd1, 32'd100);
        edges(N0 - 1);
        chk("R5 restart after threshold write, early", state, 1'b1);
        edges(1);
        chk("R5 restart after threshold write, due", state, 1'b0);
        wr(2'd3, 32'd1);

        // R4: div 1, cycles 1
        wr(2'd2, {22'd0, 2'd1, 8'd1});
        set_temp(14'd200);
        edges(N1 - 1);
        chk("R4 div1 held", state, 1'b0);
        edges(1);
        chk("R4 div1 flip", state, 1'b1);

        // R6: bypass
        wr(2'd2, 32'd0);
        set_temp(14'd50);
        edges(1);
        chk("R6 bypass next edge", state, 1'b0);
        wr(2'd3, 32'd1);

        // R8: rising only
        wr(2'd0, ctrl_w(1, 0, 1, 1));
        set_temp(14'd200);
        edges(1);
        chk("R8 rising-only on rise", irq, 1'b1);
        wr(2'd3, 32'd1);
        set_temp(14'd50);
        edges(2);
        chk("R8 rising-only ignores fall", irq, 1'b0);
        // R8: falling only
        wr(2'd0, ctrl_w(1, 0, 1, 2));
        set_temp(14'd200);
        edges(2);
        chk("R8 falling-only ignores rise", irq, 1'b0);
        set_temp(14'd50);
        edges(1);
        chk("R8 falling-only on fall", irq, 1'b1);
        wr(2'd3, 32'd1);
        // R8: none
        wr(2'd0, ctrl_w(1, 0, 1, 0));
        set_temp(14'd200);
        edges(2);
        chk("R8 none on rise", irq, 1'b0);
        set_temp(14'd50);
        edges(2);
        chk("R8 none on fall", irq, 1'b0);

        // R9: status latches with irq enable off
        wr(2'd0, ctrl_w(1, 0, 0, 3));
        set_temp(14'd200);
        edges(2);
        chk("R9 irq masked", irq, 1'b0);
        wr(2'd0, ctrl_w(1, 0, 1, 3));
        edges(0);
        chk("R9 latched status appears", irq, 1'b1);
        wr(2'd3, 32'd1);

        // R10: edge wins over simultaneous clear
        @(negedge clk);
        temp = 14'd50; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'd1;
        edges(1);
        chk("R10 state fell", state, 1'b0);
        chk("R10 set wins over clear", irq, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        wr(2'd3, 32'd1);
        edges(0);
        chk("R10 cleared afterwards", irq, 1'b0);

        // R7: global enable
        set_temp(14'd200);
        edges(1);
        chk("R7 state high before disable", state, 1'b1);
        wr(2'd3, 32'd1);
        wr(2'd0, ctrl_w(0, 0, 1, 3));
        edges(1);
        chk("R7 disable forces state low", state, 1'b0);
        chk("R7 no irq on forced fall", irq, 1'b0);
        set_temp(14'd50);
        set_temp(14'd300);
        edges(2);
        chk("R7 state stays low while disabled", state, 1'b0);
        chk("R7 no irq while disabled", irq, 1'b0);

        finish_run();
    end

endmodule